// File: doc/BRIEF.md
# Received-Byte Word Pairing and Swap Unit

This block sits behind a serial read engine. It takes the bytes returned by one slave read and writes them into an external-sensor data buffer. Before each transfer a one-cycle load pulse captures the settings: the register address the read starts at, the byte count (0 to 15), the first buffer index, a swap enable and a grouping select. Each byte then arrives with a valid strobe. An end marker may close the transfer before the count runs out.

Every byte has a register address, which is the start address plus its position in the transfer. The parity of that address decides whether the byte opens a 16-bit word or closes one. With grouping select 0, words are (even, odd) address pairs. With grouping select 1, words are (odd, even) address pairs. When swapping is off, every byte goes straight to the buffer at its own index. When swapping is on, an opening byte is held until its partner arrives. The two bytes are then written in a single cycle at exchanged positions, through a two-lane write port. A byte with no partner inside the transfer is written unswapped at its own index. This applies to a closing byte at the start and to an opening byte at the end.

Top module: `rx_word_swap`

## Requirements
- R1: After reset, `wr_be` stays 2'b00 and `wr_last` stays 0 until a byte is accepted.
- R2: With swap disabled, each accepted byte appears one cycle later with `wr_be`=2'b01, `wr_data_lo` equal to the byte, `wr_data_hi`=0, and `wr_idx` equal to base plus the byte's position in the transfer.
- R3: With swap enabled and grouping select 0, a byte at an even address followed by the byte at the next odd address gives one write with `wr_be`=2'b11. In that write, `wr_idx` is the even byte's index, `wr_data_lo` is the odd byte and `wr_data_hi` is the even byte. Lane hi addresses `wr_idx`+1.
- R4: With swap enabled and grouping select 1, words are formed from an odd-address byte and the following even-address byte, with the same lane placement as R3.
- R5: With swap enabled, if the first byte of a transfer closes a word, it is written alone and unswapped (`wr_be`=2'b01) at its own index.
- R6: With swap enabled, if the final byte of a transfer opens a word, it is written alone and unswapped (`wr_be`=2'b01) at its own index.
- R7: A transfer handles exactly as many bytes as the loaded count. Bytes after the count is reached produce no write. A count of 0 produces no write at all.
- R8: A byte accepted with `in_last`=1 ends the transfer. Later bytes produce no write until the next load.
- R9: `wr_last` is 1 only on the write that contains the transfer's final byte.
- R10: Buffer indices wrap modulo 2^IDX_W.
- R11: An opening byte held for swapping produces no write in its own cycle. Its pair write follows the partner's arrival, whatever the idle cycles between the two bytes.
- R12: A byte presented in the same cycle as the load pulse is ignored. The new settings govern the bytes that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Captures settings and starts a transfer |
| cfg_swap | input | 1 | Swap enable |
| cfg_grp | input | 1 | Grouping select: 0 even-odd, 1 odd-even |
| cfg_start_reg | input | REG_W | Register address of the first byte |
| cfg_len | input | LEN_W | Byte count of the transfer |
| cfg_base | input | IDX_W | Buffer index of the first byte |
| in_valid | input | 1 | Byte strobe |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Marks the final byte of the transfer |
| wr_be | output | 2 | Lane enables: bit 0 lane lo, bit 1 lane hi |
| wr_idx | output | IDX_W | Buffer index of lane lo (lane hi is +1) |
| wr_data_lo | output | 8 | Byte for index `wr_idx` |
| wr_data_hi | output | 8 | Byte for index `wr_idx`+1 |
| wr_last | output | 1 | This write holds the final byte |

## Verification
A word can complete in the same cycle that the transfer ends. This happens when the closing byte is also the last byte counted, or when it carries the end marker. The write must then carry both lanes and the last flag. The bench provokes this with even-length aligned transfers and with an early end marker. The expected items predict both lanes, the index and `wr_last` for that cycle. A second collision is a load pulse that arrives together with a byte strobe. This is judged by the absence of any write for the dropped byte, followed by correctly indexed writes for the next transfer.

// File: rtl/rxws_pkg.sv
package rxws_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef enum logic [1:0] {
        LANES_NONE = 2'b00,
        LANES_LO   = 2'b01,
        LANES_BOTH = 2'b11
    } lanes_e;
endpackage

// File: rtl/rxws_xfer_track.sv
// Tracks position within a transfer and decides acceptance and end.
module rxws_xfer_track #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             active,
    output logic [LEN_W-1:0] offset,
    output logic             accept,
    output logic             final_byte
);
    typedef struct packed {
        logic             active;
        logic [LEN_W-1:0] offset;
        logic [LEN_W-1:0] len;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        accept     = in_valid && trk_q.active && !cfg_load;
        final_byte = accept &&
                     (in_last || (trk_q.offset == trk_q.len - LEN_W'(1)));
        if (cfg_load) begin
            trk_d.active = (cfg_len != '0);
            trk_d.offset = '0;
            trk_d.len    = cfg_len;
        end else if (accept) begin
            trk_d.offset = trk_q.offset + LEN_W'(1);
            if (final_byte) begin
                trk_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign active = trk_q.active;
    assign offset = trk_q.offset;
endmodule

// File: rtl/rxws_parity_class.sv
// Decides whether a byte opens a word from its address parity.
module rxws_parity_class (
    input  logic start_lsb,
    input  logic offset_lsb,
    input  logic grp_odd,
    output logic opener
);
    logic addr_lsb;
    assign addr_lsb = start_lsb ^ offset_lsb;
    assign opener   = (addr_lsb == grp_odd);
endmodule

// File: rtl/rxws_hold_emit.sv
// Holds an opening byte and forms single or paired buffer writes.
module rxws_hold_emit #(
    parameter int IDX_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 swap_en,
    input  logic                 accept,
    input  logic                 final_byte,
    input  logic                 opener,
    input  rxws_pkg::byte_t      din,
    input  logic [IDX_W-1:0]     din_idx,
    output logic [1:0]           wr_be,
    output logic [IDX_W-1:0]     wr_idx,
    output rxws_pkg::byte_t      wr_lo,
    output rxws_pkg::byte_t      wr_hi,
    output logic                 wr_last,
    output logic                 held_v
);
    import rxws_pkg::*;

    typedef struct packed {
        logic             held_v;
        byte_t            held_data;
        logic [IDX_W-1:0] held_idx;
        lanes_e           be;
        logic [IDX_W-1:0] idx;
        byte_t            lo;
        byte_t            hi;
        logic             last;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.be   = LANES_NONE;
        st_d.lo   = '0;
        st_d.hi   = '0;
        st_d.last = 1'b0;
        if (flush) begin
            st_d.held_v = 1'b0;
        end else if (accept) begin
            if (swap_en && st_q.held_v) begin
                // partner closes the word: exchanged positions
                st_d.be     = LANES_BOTH;
                st_d.idx    = st_q.held_idx;
                st_d.lo     = din;
                st_d.hi     = st_q.held_data;
                st_d.last   = final_byte;
                st_d.held_v = 1'b0;
            end else if (swap_en && opener && !final_byte) begin
                st_d.held_v    = 1'b1;
                st_d.held_data = din;
                st_d.held_idx  = din_idx;
            end else begin
                st_d.be   = LANES_LO;
                st_d.idx  = din_idx;
                st_d.lo   = din;
                st_d.last = final_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{held_v: 1'b0, held_data: '0, held_idx: '0,
                      be: LANES_NONE, idx: '0, lo: '0, hi: '0, last: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_be   = st_q.be;
    assign wr_idx  = st_q.idx;
    assign wr_lo   = st_q.lo;
    assign wr_hi   = st_q.hi;
    assign wr_last = st_q.last;
    assign held_v  = st_q.held_v;
endmodule

// File: rtl/rx_word_swap.sv
module rx_word_swap #(
    parameter int REG_W = 8,
    parameter int LEN_W = 4,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic             cfg_swap,
    input  logic             cfg_grp,
    input  logic [REG_W-1:0] cfg_start_reg,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [IDX_W-1:0] cfg_base,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic [1:0]       wr_be,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data_lo,
    output logic [7:0]       wr_data_hi,
    output logic             wr_last
);
    typedef struct packed {
        logic             swap;
        logic             grp;
        logic             start_lsb;
        logic [IDX_W-1:0] base;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic             xfer_active;
    logic [LEN_W-1:0] xfer_offset;
    logic             accept;
    logic             final_byte;
    logic             opener;
    logic             held_v;
    logic [IDX_W-1:0] byte_idx;
    logic             unused_addr_hi;

    // only the address parity steers pairing
    assign unused_addr_hi = ^cfg_start_reg[REG_W-1:1];

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_load) begin
            cfg_d.swap      = cfg_swap;
            cfg_d.grp       = cfg_grp;
            cfg_d.start_lsb = cfg_start_reg[0];
            cfg_d.base      = cfg_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign byte_idx = cfg_q.base + IDX_W'(xfer_offset);

    rxws_xfer_track #(.LEN_W(LEN_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_len    (cfg_len),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .active     (xfer_active),
        .offset     (xfer_offset),
        .accept     (accept),
        .final_byte (final_byte)
    );

    rxws_parity_class u_class (
        .start_lsb  (cfg_q.start_lsb),
        .offset_lsb (xfer_offset[0]),
        .grp_odd    (cfg_q.grp),
        .opener     (opener)
    );

    rxws_hold_emit #(.IDX_W(IDX_W)) u_emit (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (cfg_load),
        .swap_en    (cfg_q.swap),
        .accept     (accept),
        .final_byte (final_byte),
        .opener     (opener),
        .din        (in_data),
        .din_idx    (byte_idx),
        .wr_be      (wr_be),
        .wr_idx     (wr_idx),
        .wr_lo      (wr_data_lo),
        .wr_hi      (wr_data_hi),
        .wr_last    (wr_last),
        .held_v     (held_v)
    );
endmodule

// File: rtl/rx_word_swap_chk.sv
module rx_word_swap_chk #(
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_load,
    input logic [LEN_W-1:0] cfg_len,
    input logic             accept,
    input logic             active,
    input logic             held_v,
    input logic [1:0]       wr_be,
    input logic             wr_last
);
    // R9
    a_r9_last_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_last |-> wr_be != 2'b00);
    // R3
    a_r3_pair_frees_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_be == 2'b11 |-> !held_v);
    // R11
    a_r11_store_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held_v) |-> wr_be == 2'b00);
    // R7
    a_r7_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> wr_be == 2'b00);
    // R7
    a_r7_zero_len_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && cfg_len == '0) |=> !active);
    // R12
    a_r12_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |-> !accept);
endmodule

bind rx_word_swap rx_word_swap_chk #(.LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .cfg_len  (cfg_len),
    .accept   (accept),
    .active   (xfer_active),
    .held_v   (held_v),
    .wr_be    (wr_be),
    .wr_last  (wr_last)
);

// File: tb/rx_word_swap_bench.sv
module rx_word_swap_bench;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_load = 1'b0, cfg_swap = 1'b0, cfg_grp = 1'b0;
    logic [7:0]       cfg_start_reg = '0;
    logic [3:0]       cfg_len = '0;
    logic [IDX_W-1:0] cfg_base = '0;
    logic             in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]       in_data = '0;
    logic [1:0]       wr_be;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data_lo, wr_data_hi;
    logic             wr_last;

    typedef struct {
        logic [1:0] be;
        int         idx;
        logic [7:0] lo;
        logic [7:0] hi;
        logic       last;
        string      tag;
    } exp_t;

    exp_t  q[$];
    int    n_chk = 0, n_fail = 0;
    string cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_word_swap #(.REG_W(8), .LEN_W(4), .IDX_W(IDX_W)) u_rx_word_swap (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_swap(cfg_swap),
        .cfg_grp(cfg_grp), .cfg_start_reg(cfg_start_reg), .cfg_len(cfg_len),
        .cfg_base(cfg_base), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .wr_be(wr_be), .wr_idx(wr_idx),
        .wr_data_lo(wr_data_lo), .wr_data_hi(wr_data_hi), .wr_last(wr_last)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // monitor: compare every produced write against the scoreboard
    always @(negedge clk) begin
        if (rst_n && wr_be != 2'b00) begin
            if (q.size() == 0) begin
                chk(1'b0, cur_tag, "unexpected write idx", int'(wr_idx), -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(wr_be == e.be && int'(wr_idx) == e.idx &&
                    wr_data_lo == e.lo && wr_data_hi == e.hi, e.tag,
                    "write {be,idx,hi,lo}",
                    int'({wr_be, 3'b0, wr_idx, wr_data_hi, wr_data_lo}),
                    int'({e.be, 3'b0, IDX_W'(e.idx), e.hi, e.lo}));
                chk(wr_last == e.last, "R9", "last flag",
                    int'(wr_last), int'(e.last));
            end
        end
    end

    task automatic push(input logic [1:0] be, input int idx, input logic [7:0] lo,
                        input logic [7:0] hi, input logic last, input string tag);
        exp_t e;
        e.be = be; e.idx = idx % (1 << IDX_W); e.lo = lo; e.hi = hi;
        e.last = last; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic run_xfer(input bit sw, input bit grp, input logic [7:0] st,
                            input int len, input int base, input int nbytes,
                            input int last_at, input int gap, input bit overlap,
                            input string tag);
        bit         act;
        bit         held = 1'b0;
        int         held_idx = 0;
        logic [7:0] held_d = '0;
        cur_tag = tag;
        @(negedge clk);
        cfg_load = 1'b1; cfg_swap = sw; cfg_grp = grp; cfg_start_reg = st;
        cfg_len = 4'(len); cfg_base = IDX_W'(base);
        in_valid = overlap; in_data = 8'hEE; in_last = 1'b0;
        @(negedge clk);
        cfg_load = 1'b0; in_valid = 1'b0;
        act = (len != 0);
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] d;
            logic [7:0] addr;
            bit         fin, opn;
            d    = (8'h51 + 8'(i * 23)) ^ st;
            addr = st + 8'(i);
            fin  = act && ((i == len - 1) || (i == last_at));
            opn  = (addr[0] == grp);
            if (act) begin
                if (sw && held) begin
                    push(2'b11, held_idx, d, held_d, fin, tag);
                    held = 1'b0;
                end else if (sw && opn && !fin) begin
                    held = 1'b1; held_idx = base + i; held_d = d;
                end else begin
                    push(2'b01, base + i, d, 8'h00, fin, tag);
                end
                if (fin) act = 1'b0;
            end
            in_valid = 1'b1; in_data = d; in_last = (i == last_at);
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
            repeat (gap) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk(q.size() == 0, tag, "pending expected writes", q.size(), 0);
        q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(wr_be == 2'b00 && wr_last == 1'b0, "R1", "reset outputs",
            int'({wr_be, wr_last}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(wr_be == 2'b00, "R1", "idle after reset", int'(wr_be), 0);

        run_xfer(1'b0, 1'b0, 8'h3B, 6, 0, 6, -1, 0, 1'b0, "R2");
        run_xfer(1'b1, 1'b0, 8'h40, 6, 2, 6, -1, 0, 1'b0, "R3");
        run_xfer(1'b1, 1'b1, 8'h41, 6, 4, 6, -1, 0, 1'b0, "R4");
        run_xfer(1'b1, 1'b0, 8'h43, 5, 8, 5, -1, 0, 1'b0, "R5");
        run_xfer(1'b1, 1'b1, 8'h20, 4, 1, 4, -1, 0, 1'b0, "R5");
        run_xfer(1'b1, 1'b0, 8'h40, 5, 0, 5, -1, 0, 1'b0, "R6");
        run_xfer(1'b1, 1'b0, 8'h00, 3, 3, 6, -1, 0, 1'b0, "R7");
        run_xfer(1'b1, 1'b0, 8'h00, 0, 3, 3, -1, 0, 1'b0, "R7");
        run_xfer(1'b1, 1'b0, 8'h00, 15, 0, 15, -1, 0, 1'b0, "R7");
        run_xfer(1'b1, 1'b0, 8'h00, 8, 5, 6, 2, 0, 1'b0, "R8");
        run_xfer(1'b1, 1'b0, 8'h10, 8, 5, 6, 3, 0, 1'b0, "R8");
        run_xfer(1'b1, 1'b0, 8'h00, 5, 30, 5, -1, 0, 1'b0, "R10");
        run_xfer(1'b0, 1'b0, 8'h00, 4, 30, 4, -1, 0, 1'b0, "R10");
        run_xfer(1'b1, 1'b0, 8'h10, 4, 6, 4, -1, 3, 1'b0, "R11");
        run_xfer(1'b1, 1'b1, 8'h33, 6, 9, 6, -1, 0, 1'b1, "R12");
        run_xfer(1'b0, 1'b0, 8'h07, 3, 12, 3, -1, 1, 1'b1, "R12");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule